// File: doc/BRIEF.md
# Nested Translation Lookaside Buffer

This block is a small, fully associative cache of guest-physical to system-physical page translations. A two-dimensional page walker consults it with the guest physical address of a guest page table entry. On a hit, the walker gets back the system physical address of that entry in the same cycle. It then skips the complete nested walk that would otherwise precede the access to that guest level. The first lookup of a walk uses the address of the top-level guest entry.

Each entry maps one 4 KiB guest physical page to one system frame, taken from the final nested-level entry. The tag is guest physical address bits [51:12] and the stored data is system frame bits [51:12]. The returned address joins the stored frame with the page offset, bits [11:0], of the looked-up address. A walker installs a translation through the fill port once a nested walk completes. Victims are chosen round-robin, and a flush input invalidates the whole buffer.

Top module: `nested_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. While `lk_hit` is 0, `lk_spa` is all zeros.
- R2: With `lk_valid` high and no flush, `lk_hit` is 1 in the same cycle when a valid entry's tag equals `lk_gpa[51:12]`.
- R3: On a hit, `lk_spa[51:12]` is the stored frame of the matching entry and `lk_spa[11:0]` equals `lk_gpa[11:0]`.
- R4: A fill whose tag matches no valid entry writes the entry at the replacement pointer. The pointer then advances by one and wraps after the last entry. It is 0 after reset, so with 8 entries the ninth distinct fill evicts the first one installed.
- R5: A fill whose tag matches a valid entry overwrites that entry's frame in place and leaves the replacement pointer unchanged.
- R6: At most one valid entry ever matches a given tag.
- R7: A flush invalidates all entries and returns the replacement pointer to 0. A lookup in the flush cycle misses.
- R8: A fill presented in the same cycle as a flush is discarded.
- R9: A fill becomes visible from the next cycle. A lookup in the fill cycle sees the contents held before the fill.
- R10: With `lk_valid` low, `lk_hit` is 0 whatever the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_gpa | input | 52 | Guest physical address of the guest table entry |
| lk_hit | output | 1 | Lookup hit |
| lk_spa | output | 52 | System physical address of the entry on a hit, zero otherwise |
| fill_valid | input | 1 | Install a translation |
| fill_gpa | input | 52 | Guest physical address whose page is installed (bits [51:12] used) |
| fill_frame | input | 40 | System frame number, bits [51:12] of the system address |

## Verification
The assertions take for granted that the inputs are known after reset, and that the buffer's contents change only through the fill and flush ports. They also rely on fills arriving one per cycle with a single page tag. The uniqueness check depends on the rule that a fill updates an existing match instead of allocating a new entry. The stimulus drives every input from a single process at the falling edge, so each input is always defined. It draws tags from a pool of twelve, a little larger than the buffer, so that repeated tags, overwrites and evictions all recur. It also places fills, lookups and flushes in the same cycle to exercise the ordering rules.

// File: rtl/nested_tlb.sv
module nested_tlb #(
  parameter int PA_W    = 52,
  parameter int PG_BITS = 12,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lk_valid,
  input  logic [PA_W-1:0] lk_gpa,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_spa,
  input  logic            fill_valid,
  input  logic [PA_W-1:0] fill_gpa,
  input  logic [PA_W-PG_BITS-1:0] fill_frame
);
  localparam int TAG_W = PA_W - PG_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TAG_W-1:0]   frm_q [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [TAG_W-1:0]   hit_frame;
  logic [IDX_W-1:0]   fl_idx, wr_idx;
  logic               fl_hit, do_fill;

  wire [TAG_W-1:0] lk_tag = lk_gpa[PA_W-1:PG_BITS];
  wire [TAG_W-1:0] fl_tag = fill_gpa[PA_W-1:PG_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && (tag_q[g] == lk_tag);
    assign fl_match[g] = vld[g] && (tag_q[g] == fl_tag);
  end

  always_comb begin
    hit_frame = '0;
    fl_idx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) hit_frame = hit_frame | frm_q[i];
      if (fl_match[i]) fl_idx = IDX_W'(i);
    end
  end

  assign fl_hit  = |fl_match;
  assign do_fill = fill_valid && !flush;
  assign wr_idx  = fl_hit ? fl_idx : ptr;

  assign lk_hit = lk_valid && !flush && (|lk_match);
  assign lk_spa = lk_hit ? {hit_frame, lk_gpa[PG_BITS-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (do_fill) begin
      vld[wr_idx] <= 1'b1;
      if (!fl_hit) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_fill) begin
      tag_q[wr_idx] <= fl_tag;
      frm_q[wr_idx] <= fill_frame;
    end
  end

  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0 && ptr == '0));

  a_r4_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && !fl_hit) |=>
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && fl_hit) |=> $stable(ptr));

  a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> vld[$past(wr_idx)]);

  a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_spa == '0));

  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
endmodule

// File: tb/nested_tlb_test.sv
module nested_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [51:0] lk_gpa = '0;
  logic        fill_valid = 1'b0;
  logic [51:0] fill_gpa = '0;
  logic [39:0] fill_frame = '0;
  logic        lk_hit;
  logic [51:0] lk_spa;

  nested_tlb uut (.clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
                  .lk_gpa(lk_gpa), .lk_hit(lk_hit), .lk_spa(lk_spa),
                  .fill_valid(fill_valid), .fill_gpa(fill_gpa), .fill_frame(fill_frame));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  logic [39:0] m_tag [8];
  logic [39:0] m_frm [8];
  bit          m_vld [8];
  int          m_ptr = 0;

  function automatic logic [51:0] ga(input logic [39:0] t, input logic [11:0] o);
    return {t, o};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic step(input bit lv, input logic [51:0] lg, input bit fv,
                      input logic [51:0] fg, input logic [39:0] fr,
                      input bit fl, input string req);
    bit          e_hit;
    logic [51:0] e_spa;
    int          idx;
    @(negedge clk);
    lk_valid = lv; lk_gpa = lg; fill_valid = fv; fill_gpa = fg;
    fill_frame = fr; flush = fl;
    #1;
    e_hit = 1'b0; e_spa = '0;
    if (lv && !fl)
      for (int i = 0; i < 8; i++)
        if (m_vld[i] && m_tag[i] == lg[51:12]) begin
          e_hit = 1'b1; e_spa = {m_frm[i], lg[11:0]};
        end
    vectors++;
    if (lk_hit !== e_hit || lk_spa !== e_spa) begin
      errors++;
      $display("FAIL %s: hit=%0b spa=%h expected hit=%0b spa=%h",
               req, lk_hit, lk_spa, e_hit, e_spa);
    end
    @(posedge clk);
    if (fl) model_reset();
    else if (fv) begin
      idx = -1;
      for (int i = 0; i < 8; i++)
        if (m_vld[i] && m_tag[i] == fg[51:12]) idx = i;
      if (idx < 0) begin
        idx = m_ptr;
        m_ptr = (m_ptr + 1) % 8;
      end
      m_vld[idx] = 1'b1; m_tag[idx] = fg[51:12]; m_frm[idx] = fr;
    end
  endtask

  task automatic look(input logic [51:0] g, input string req);
    step(1, g, 0, '0, '0, 0, req);
  endtask

  task automatic fill(input logic [39:0] t, input logic [39:0] fr, input string req);
    step(0, '0, 1, ga(t, 12'h0), fr, 0, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty after reset
    look(ga(40'h1, 12'h123), "R1");
    look(ga(40'h0, 12'h000), "R1");
    // R2 R3 R9: lookup in fill cycle sees old contents, then hits
    step(1, ga(40'hA, 12'h044), 1, ga(40'hA, 12'hFFF), 40'hBEEF0, 0, "R9");
    look(ga(40'hA, 12'h044), "R2");
    look(ga(40'hA, 12'hABC), "R3");
    // R10: idle lookup port
    step(0, ga(40'hA, 12'h0), 0, '0, '0, 0, "R10");
    // R4: fill to capacity then evict oldest
    for (int i = 1; i < 8; i++) fill(40'h100 + 40'(i), 40'h5000 + 40'(i), "R4");
    for (int i = 1; i < 8; i++) look(ga(40'h100 + 40'(i), 12'(i)), "R4");
    look(ga(40'hA, 12'h7), "R4");
    fill(40'h200, 40'h777, "R4");
    look(ga(40'hA, 12'h7), "R4");
    look(ga(40'h200, 12'h8), "R4");
    // R5: overwrite in place, pointer untouched
    fill(40'h103, 40'hCAFE, "R5");
    look(ga(40'h103, 12'h1), "R5");
    fill(40'h201, 40'h888, "R5");
    look(ga(40'h101, 12'h2), "R5");
    look(ga(40'h102, 12'h2), "R5");
    look(ga(40'h103, 12'h2), "R5");
    // R7 R8: flush with same-cycle lookup and fill
    step(1, ga(40'h102, 12'h9), 1, ga(40'h300, 12'h0), 40'h99, 1, "R7");
    look(ga(40'h102, 12'h9), "R7");
    look(ga(40'h300, 12'h0), "R8");
    fill(40'h400, 40'h41, "R7");
    look(ga(40'h400, 12'h5), "R7");
    // mixed traffic, R6 via repeated tags
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [39:0] t1, t2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t1 = 40'(lfsr[3:0] % 12);
      t2 = 40'(lfsr[9:6] % 12);
      step(lfsr[4], ga(t1, {lfsr[15:10], lfsr[5:0]}), lfsr[5] | lfsr[11],
           ga(t2, 12'h0), {24'h0, lfsr}, (lfsr[15:12] == 4'hF), "R6");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule